// File: doc/BRIEF.md
# Double-Buffered Time-Slot Switch

This block switches bytes between time slots of a telephony frame. The frame is 125 µs long and has 32 slots by default. Each incoming byte arrives with its slot index and is stored in a data memory that holds two pages. In any one frame, one page is live and the other is held. A frame strobe swaps the two roles. Incoming bytes are always stored in the live page, so the held page keeps the bytes of the previous frame.

Each output slot has its own entry in a connection table. The entry holds:
- a source slot;
- a page-choice bit;
- a pattern-enable bit;
- an 8-bit tag.

When the page-choice bit is clear, the output reads the live page. A byte stored earlier in the same frame then comes out with minimum delay. When the bit is set, the output reads the held page. The byte then appears exactly one frame after it arrived, which gives constant delay. When pattern-enable is set, the output carries the tag and ignores the data memory. The downstream serialiser requests each output slot, and the byte appears one cycle later.

Top module: `slot_switch`

## Requirements
- R1: Reset has these effects:
  - every data-memory byte is zero;
  - every table entry is zero (source slot 0, live page, pattern off, tag 0);
  - page 0 is live;
  - `out_valid` and `out_byte` are low.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `out_req` is high, and low in every other cycle. `out_byte` is updated only in those cycles and holds its value otherwise.
- R3: Minimum delay: if `cm_inact`=0, a request reads the live page at the entry's source slot. A byte stored in an earlier cycle of the same frame is returned.
- R4: Constant delay: if `cm_inact`=1, a request reads the held page. A byte stored during one frame is returned after the next frame strobe, exactly one frame later.
- R5: Each cycle with `frame_i` high swaps the live and held pages at that clock edge. After two strobes, the live page again shows the bytes that were stored two frames earlier, until those bytes are overwritten.
- R6: If an entry has pattern-enable=1, a request for that slot returns the entry's 8-bit tag, whatever the data memory holds.
- R7: A stored input byte never changes the held page. A constant-delay output keeps returning the previous frame's byte even after the same source slot is rewritten.
- R8: A table write takes effect for requests in later cycles. It changes only the entry at `cm_addr`.
- R9: No byte is stored in a cycle with `in_valid` low, whatever `in_slot` and `in_byte` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Frame-boundary strobe that swaps the pages |
| in_valid | input | 1 | Incoming byte is present |
| in_slot | input | 5 | Slot index of the incoming byte |
| in_byte | input | 8 | Incoming byte |
| out_req | input | 1 | Request for an output slot |
| out_slot | input | 5 | Output slot being requested |
| out_valid | output | 1 | `out_byte` holds the byte for the previous request |
| out_byte | output | 8 | Switched or pattern byte |
| cm_we | input | 1 | Write strobe for the connection table |
| cm_addr | input | 5 | Output slot whose entry is written |
| cm_src | input | 5 | Source slot for that entry |
| cm_inact | input | 1 | 1 selects the held page (constant delay), 0 selects the live page |
| cm_pat | input | 1 | 1 makes the output carry the tag |
| cm_tag | input | 8 | Pattern byte |

## Verification
The hardest state to reach from the ports is one where the two pages of a single source slot hold different bytes. Only then can a reader tell whether the right page was chosen, and whether a write avoided the held page. The stimulus stores a byte, strobes a frame, and stores a second byte in the same slot. It then reads that slot through one minimum-delay output and one constant-delay output. A second strobe then exposes the two-frame-old byte on the live page.

// File: rtl/slot_switch.sv
module slot_switch #(
  parameter int SLOTS = 32,
  parameter int SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_i,
  input  logic          in_valid,
  input  logic [SW-1:0] in_slot,
  input  logic [7:0]    in_byte,
  input  logic          out_req,
  input  logic [SW-1:0] out_slot,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  input  logic          cm_we,
  input  logic [SW-1:0] cm_addr,
  input  logic [SW-1:0] cm_src,
  input  logic          cm_inact,
  input  logic          cm_pat,
  input  logic [7:0]    cm_tag
);
  localparam int WORDS = 2 * SLOTS;

  logic                       live_pg;
  logic [WORDS-1:0][7:0]      mem;
  logic [SLOTS-1:0][SW-1:0]   c_src;
  logic [SLOTS-1:0]           c_inact;
  logic [SLOTS-1:0]           c_pat;
  logic [SLOTS-1:0][7:0]      c_tag;

  logic          rd_pg;
  logic [7:0]    rd_byte;

  assign rd_pg   = live_pg ^ c_inact[out_slot];
  assign rd_byte = c_pat[out_slot] ? c_tag[out_slot] : mem[{rd_pg, c_src[out_slot]}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_pg   <= 1'b0;
      mem       <= '0;
      c_src     <= '0;
      c_inact   <= '0;
      c_pat     <= '0;
      c_tag     <= '0;
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
    end else begin
      if (frame_i) live_pg <= ~live_pg;
      if (in_valid) mem[{live_pg, in_slot}] <= in_byte;
      if (cm_we) begin
        c_src[cm_addr]   <= cm_src;
        c_inact[cm_addr] <= cm_inact;
        c_pat[cm_addr]   <= cm_pat;
        c_tag[cm_addr]   <= cm_tag;
      end
      out_valid <= out_req;
      if (out_req) out_byte <= rd_byte;
    end
  end

  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_req |=> (!out_valid && $stable(out_byte)));
  assert_page_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (live_pg != $past(live_pg)));
  assert_page_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |=> $stable(live_pg));
  assert_pattern_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && c_pat[out_slot]) |=> (out_byte == $past(c_tag[out_slot])));
  assert_held_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (mem[{~$past(live_pg), $past(in_slot)}] == $past(mem[{~live_pg, in_slot}])));
  assert_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(mem));
endmodule

// File: tb/test_slot_switch.sv
module test_slot_switch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_i = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] in_slot = '0;
  logic [7:0] in_byte = '0;
  logic       out_req = 1'b0;
  logic [4:0] out_slot = '0;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       cm_we = 1'b0;
  logic [4:0] cm_addr = '0;
  logic [4:0] cm_src = '0;
  logic       cm_inact = 1'b0;
  logic       cm_pat = 1'b0;
  logic [7:0] cm_tag = '0;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  slot_switch i_slot_switch (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
    .in_valid(in_valid), .in_slot(in_slot), .in_byte(in_byte),
    .out_req(out_req), .out_slot(out_slot),
    .out_valid(out_valid), .out_byte(out_byte),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_src(cm_src),
    .cm_inact(cm_inact), .cm_pat(cm_pat), .cm_tag(cm_tag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [4:0] s, input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_slot = s; in_byte = b;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); frame_i = 1'b1;
    @(negedge clk); frame_i = 1'b0;
  endtask

  task automatic conn(input logic [4:0] o, input logic [4:0] s,
                      input logic ia, input logic pt, input logic [7:0] tg);
    @(negedge clk); cm_we = 1'b1; cm_addr = o; cm_src = s;
    cm_inact = ia; cm_pat = pt; cm_tag = tg;
    @(negedge clk); cm_we = 1'b0;
  endtask

  task automatic fetch(input logic [4:0] o, input string req, input int exp);
    @(negedge clk); out_req = 1'b1; out_slot = o;
    @(negedge clk); out_req = 1'b0;
    check("R2 valid", int'(out_valid), 1);
    check(req, int'(out_byte), exp);
  endtask

  task automatic t_reset();
    check("R1 valid", int'(out_valid), 0);
    check("R1 byte", int'(out_byte), 0);
    fetch(5'd0, "R1 memory zero", 8'h00);
    @(negedge clk);
    check("R2 valid drops", int'(out_valid), 0);
    check("R2 byte holds", int'(out_byte), 8'h00);
  endtask

  task automatic t_min_delay();
    strobe();
    conn(5'd3, 5'd5, 1'b0, 1'b0, 8'h00);
    put(5'd5, 8'hA5);
    fetch(5'd3, "R3 same frame", 8'hA5);
  endtask

  task automatic t_const_delay();
    conn(5'd4, 5'd5, 1'b1, 1'b0, 8'h00);
    fetch(5'd4, "R4 held before strobe", 8'h00);
    strobe();
    fetch(5'd4, "R4 one frame later", 8'hA5);
    fetch(5'd3, "R5 live shows two-frame-old", 8'h00);
    put(5'd5, 8'h3C);
    fetch(5'd4, "R7 held untouched", 8'hA5);
    fetch(5'd3, "R3 new live byte", 8'h3C);
  endtask

  task automatic t_two_frames();
    strobe();
    fetch(5'd3, "R5 second swap", 8'hA5);
    fetch(5'd4, "R4 previous frame", 8'h3C);
  endtask

  task automatic t_pattern();
    conn(5'd7, 5'd5, 1'b0, 1'b1, 8'h5A);
    fetch(5'd7, "R6 tag out", 8'h5A);
    put(5'd5, 8'h11);
    fetch(5'd7, "R6 ignores memory", 8'h5A);
    conn(5'd7, 5'd5, 1'b0, 1'b0, 8'h5A);
    fetch(5'd7, "R8 pattern cleared", 8'h11);
  endtask

  task automatic t_no_store();
    @(negedge clk); in_valid = 1'b0; in_slot = 5'd5; in_byte = 8'hFF;
    @(negedge clk); in_byte = 8'h00;
    fetch(5'd3, "R9 no store", 8'h11);
  endtask

  task automatic t_entries();
    conn(5'd8, 5'd9, 1'b0, 1'b0, 8'h00);
    fetch(5'd3, "R8 other entry kept", 8'h11);
    put(5'd9, 8'h77);
    fetch(5'd8, "R8 new entry", 8'h77);
    fetch(5'd31, "R8 untouched entry reads slot 0", 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_min_delay();
        t_const_delay();
        t_two_frames();
        t_pattern();
        t_no_store();
        t_entries();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule